// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded Program and Erase

This block is a byte-wide flash memory controller. It holds its own storage array, split into equal sectors, and listens to a simple microprocessor bus whose chip-enable, write-enable and output-enable strobes are already sampled into the clock domain. A host writes command codes and operands over that bus. The controller then runs the program or erase work by itself. A program operation pulses and verifies one byte. An erase operation first drives every targeted byte to zero, then pulses the selected sectors back to all ones and verifies them.

While an operation runs, the host keeps reading the same location to track it. Each read returns a status byte instead of array data. In that byte, bit 7 is a polling bit and bit 6 changes on every read. Once both stop changing, the array data is back on the bus and the controller has returned to read mode without any host action. A supply-low input blocks every change to the array.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every byte of the array reads 8'hFF, `op_fail` is 0 and `dq_oe` is 0.
- R2: A bus write is accepted only on a cycle where `we_n` falls while `ce_n` is 0 and `oe_n` is 1. A write made with `oe_n` at 0 has no effect.
- R3: `dq_oe` is 1 in the cycle after a cycle where both `ce_n` and `oe_n` are 0, and is 0 otherwise. While `dq_oe` is 0, `dq` is 8'h00.
- R4: Writing 8'hA0 and then writing a byte D at address A programs the array so that A holds old AND D. The byte is verified, and the controller then returns to read mode by itself.
- R5: While an operation runs, a read returns a status byte with bits 5..0 at 0. During program, bit 7 is the inverse of bit 7 of D. During erase, including the sector-collection window, bit 7 is 0.
- R6: Status bit 6 inverts on every new read (a cycle where `ce_n` and `oe_n` become both low) while busy. It does not change while idle, so two consecutive reads agree once the operation has finished.
- R7: If the verify does not match D after MAX_TRIES program pulses, `op_fail` goes to 1 and the controller returns to read mode. Any later accepted command write (8'hA0, 8'h80 or 8'hF0 in read mode) clears `op_fail`.
- R8: Writing 8'h80 and then 8'h30 at an address in sector S (sector = address bits [8:6]) opens a collection window. Each further 8'h30 write adds its sector and restarts the window. After COLLECT_CYCLES idle cycles the collected sectors become all 8'hFF, and all other sectors are unchanged.
- R9: Writing 8'h80 and then 8'h10 erases every sector to 8'hFF.
- R10: Before the erase pulse, every byte of each selected sector that is not already 8'h00 is written to 8'h00.
- R11: While `supply_low` is 1, bus writes are discarded and no array byte changes.
- R12: During the collection window, a write of any data other than 8'h30 cancels the erase. No byte changes, and the controller is back in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, already sampled |
| we_n | input | 1 | Write enable, active low, already sampled |
| oe_n | input | 1 | Output enable, active low, already sampled |
| addr | input | ADDR_W | Byte address; the top bits select the sector |
| din | input | 8 | Write data or command code |
| supply_low | input | 1 | Low-supply detect; blocks all writes |
| dq | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Read data is being driven |
| op_fail | output | 1 | Last program failed verification |

## Verification
A status read and the end of an operation can fall on the same clock edge. The controller leaves its busy state in the same cycle that a read begins, so the bit-6 inversion and the hand-over from status to array data meet in one edge. The bench provokes this by polling without pause, one read every two cycles, through every program and erase. It judges the outcome by requiring that polling ends with two equal reads whose value matches the reference array. It also requires that the first two reads of each operation differ in bit 6 and carry the expected bit 7.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_PSET, ST_PPULSE, ST_PVERIFY,
        ST_ESET, ST_ECOL, ST_EPRE, ST_EPULSE, ST_EVERIFY
    } fcc_state_e;

    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ESET  = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    function automatic logic is_busy(fcc_state_e s);
        return (s == ST_PPULSE) || (s == ST_PVERIFY) || (s == ST_ECOL) ||
               (s == ST_EPRE) || (s == ST_EPULSE) || (s == ST_EVERIFY);
    endfunction

    function automatic logic is_prog(fcc_state_e s);
        return (s == ST_PPULSE) || (s == ST_PVERIFY);
    endfunction
endpackage

// File: rtl/fcc_bus_decode.sv
module fcc_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb,
    output logic rd_act,
    output logic rd_start
);
    typedef struct packed {
        logic we_hi;
        logic rd_prev;
    } dec_t;

    dec_t q, d;

    always_comb begin
        d         = q;
        rd_act    = !ce_n && !oe_n;
        wr_stb    = !we_n && !ce_n && oe_n && q.we_hi;
        rd_start  = rd_act && !q.rd_prev;
        d.we_hi   = we_n;
        d.rd_prev = rd_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int SECTORS      = 8,
    parameter int SECTOR_BYTES = 64,
    localparam int DEPTH       = SECTORS * SECTOR_BYTES,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      host_addr,
    output logic [7:0]         host_data,
    input  logic [AW-1:0]      int_addr,
    output logic [7:0]         int_data,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               erase_en,
    input  logic [SECTORS-1:0] erase_mask,
    output logic [SECTORS-1:0] sec_ones,
    output logic [SECTORS-1:0] sec_zero
);
    logic [7:0] mem [DEPTH];

    assign host_data = mem[host_addr];
    assign int_data  = mem[int_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (erase_en) begin
                for (int i = 0; i < DEPTH; i++)
                    if (erase_mask[i / SECTOR_BYTES]) mem[i] <= 8'hFF;
            end
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end

    for (genvar s = 0; s < SECTORS; s++) begin : g_sec
        logic all1, all0;
        always_comb begin
            all1 = 1'b1;
            all0 = 1'b1;
            for (int b = 0; b < SECTOR_BYTES; b++) begin
                all1 = all1 & (&mem[s*SECTOR_BYTES + b]);
                all0 = all0 & ~(|mem[s*SECTOR_BYTES + b]);
            end
        end
        assign sec_ones[s] = all1;
        assign sec_zero[s] = all0;
    end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int SECTORS        = 8,
    parameter int SECTOR_BYTES   = 64,
    parameter int PGM_CYCLES     = 6,
    parameter int ERASE_CYCLES   = 20,
    parameter int MAX_TRIES      = 3,
    parameter int COLLECT_CYCLES = 16,
    localparam int DEPTH         = SECTORS * SECTOR_BYTES,
    localparam int AW            = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_low,
    input  logic               wr_stb,
    input  logic [AW-1:0]      bus_addr,
    input  logic [7:0]         bus_data,
    input  logic [7:0]         int_data,
    input  logic [SECTORS-1:0] sec_ones,
    input  logic [SECTORS-1:0] sec_zero,
    output logic [AW-1:0]      int_addr,
    output logic               arr_we,
    output logic [AW-1:0]      arr_waddr,
    output logic [7:0]         arr_wdata,
    output logic               arr_erase,
    output logic [SECTORS-1:0] arr_emask,
    output logic               busy,
    output logic               poll_bit,
    output logic               fault
);
    localparam int SW    = $clog2(SECTORS);
    localparam int CMAX0 = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
    localparam int CMAX  = (CMAX0 > COLLECT_CYCLES) ? CMAX0 : COLLECT_CYCLES;
    localparam int CW    = $clog2(CMAX + 1);
    localparam int TW    = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        fcc_state_e         state;
        logic [AW-1:0]      addr;
        logic [7:0]         data;
        logic [CW-1:0]      cnt;
        logic [TW-1:0]      tries;
        logic [SECTORS-1:0] mask;
        logic               fault;
    } seq_t;

    seq_t q, d;
    logic accept;
    logic [SW-1:0] bus_sec, ptr_sec;

    always_comb begin
        d         = q;
        accept    = wr_stb && !supply_low;
        bus_sec   = bus_addr[AW-1 -: SW];
        ptr_sec   = q.addr[AW-1 -: SW];
        int_addr  = q.addr;
        arr_we    = 1'b0;
        arr_waddr = q.addr;
        arr_wdata = 8'h00;
        arr_erase = 1'b0;
        arr_emask = q.mask;
        case (q.state)
            ST_READ: if (accept) begin
                if (bus_data == CMD_PROG) begin
                    d.state = ST_PSET;
                    d.fault = 1'b0;
                end else if (bus_data == CMD_ESET) begin
                    d.state = ST_ESET;
                    d.fault = 1'b0;
                end else if (bus_data == CMD_RESET) begin
                    d.fault = 1'b0;
                end
            end
            ST_PSET: if (accept) begin
                d.state = ST_PPULSE;
                d.addr  = bus_addr;
                d.data  = bus_data;
                d.cnt   = '0;
                d.tries = '0;
            end
            ST_PPULSE: if (!supply_low) begin
                if (q.cnt == CW'(PGM_CYCLES - 1)) begin
                    arr_we    = 1'b1;
                    arr_wdata = int_data & q.data;
                    d.state   = ST_PVERIFY;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PVERIFY: if (!supply_low) begin
                if (int_data == q.data) begin
                    d.state = ST_READ;
                end else if (q.tries == TW'(MAX_TRIES - 1)) begin
                    d.state = ST_READ;
                    d.fault = 1'b1;
                end else begin
                    d.tries = q.tries + 1'b1;
                    d.cnt   = '0;
                    d.state = ST_PPULSE;
                end
            end
            ST_ESET: if (accept) begin
                if (bus_data == CMD_CHIP) begin
                    d.mask  = '1;
                    d.addr  = '0;
                    d.state = ST_EPRE;
                end else if (bus_data == CMD_SECT) begin
                    d.mask  = SECTORS'(1) << bus_sec;
                    d.cnt   = '0;
                    d.state = ST_ECOL;
                end else begin
                    d.state = ST_READ;
                end
            end
            ST_ECOL: begin
                if (accept) begin
                    if (bus_data == CMD_SECT) begin
                        d.mask = q.mask | (SECTORS'(1) << bus_sec);
                        d.cnt  = '0;
                    end else begin
                        d.mask  = '0;
                        d.state = ST_READ;
                    end
                end else if (!supply_low) begin
                    if (q.cnt == CW'(COLLECT_CYCLES - 1)) begin
                        d.addr  = '0;
                        d.state = ST_EPRE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_EPRE: if (!supply_low) begin
                if (q.mask[ptr_sec] && (int_data != 8'h00)) arr_we = 1'b1;
                if (q.addr == AW'(DEPTH - 1)) begin
                    d.cnt   = '0;
                    d.state = ST_EPULSE;
                end else begin
                    d.addr = q.addr + 1'b1;
                end
            end
            ST_EPULSE: if (!supply_low) begin
                if (q.cnt == CW'(ERASE_CYCLES - 1)) begin
                    arr_erase = 1'b1;
                    d.state   = ST_EVERIFY;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_EVERIFY: if (!supply_low) begin
                if ((sec_ones & q.mask) != q.mask) d.fault = 1'b1;
                d.mask  = '0;
                d.state = ST_READ;
            end
            default: d.state = ST_READ;
        endcase
        busy     = is_busy(q.state);
        poll_bit = is_prog(q.state) ? ~q.data[7] : 1'b0;
        fault    = q.fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_READ;
        end else begin
            q <= d;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_READ && !wr_stb) |=> (q.state == ST_READ));
    // R8
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ECOL) |-> (q.mask != '0));
    // R10
    preprog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> ((sec_zero & q.mask) == q.mask));
    // R7
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fault) |-> ($past(q.state) == ST_PVERIFY || $past(q.state) == ST_EVERIFY));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int SECTORS        = 8,
    parameter int SECTOR_BYTES   = 64,
    parameter int PGM_CYCLES     = 6,
    parameter int ERASE_CYCLES   = 20,
    parameter int MAX_TRIES      = 3,
    parameter int COLLECT_CYCLES = 16,
    localparam int ADDR_W        = $clog2(SECTORS * SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              supply_low,
    output logic [7:0]        dq,
    output logic              dq_oe,
    output logic              op_fail
);
    logic wr_stb, rd_act, rd_start;
    logic [7:0] host_data, int_data, arr_wdata;
    logic [ADDR_W-1:0] int_addr, arr_waddr;
    logic arr_we, arr_erase, busy, poll_bit, fault;
    logic [SECTORS-1:0] arr_emask, sec_ones, sec_zero;

    fcc_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_stb(wr_stb), .rd_act(rd_act), .rd_start(rd_start)
    );

    fcc_array #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .host_addr(addr), .host_data(host_data),
        .int_addr(int_addr), .int_data(int_data),
        .wr_en(arr_we), .wr_addr(arr_waddr), .wr_data(arr_wdata),
        .erase_en(arr_erase), .erase_mask(arr_emask),
        .sec_ones(sec_ones), .sec_zero(sec_zero)
    );

    fcc_seq #(
        .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .PGM_CYCLES(PGM_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .MAX_TRIES(MAX_TRIES),
        .COLLECT_CYCLES(COLLECT_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wr_stb(wr_stb),
        .bus_addr(addr), .bus_data(din), .int_data(int_data),
        .sec_ones(sec_ones), .sec_zero(sec_zero), .int_addr(int_addr),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .arr_erase(arr_erase), .arr_emask(arr_emask),
        .busy(busy), .poll_bit(poll_bit), .fault(fault)
    );

    typedef struct packed {
        logic       tog;
        logic [7:0] dq;
        logic       oe;
    } out_t;

    out_t q, d;

    always_comb begin
        d     = q;
        d.tog = q.tog ^ (rd_start && busy);
        d.oe  = rd_act;
        if (!rd_act)   d.dq = 8'h00;
        else if (busy) d.dq = {poll_bit, d.tog, 6'b0};
        else           d.dq = host_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dq      = q.dq;
    assign dq_oe   = q.oe;
    assign op_fail = fault;

    // R3
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (!dq_oe && dq == 8'h00));
    // R6
    tog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(q.tog));
    // R11
    low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !(arr_we || arr_erase));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dq;
    logic dq_oe, op_fail;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    flash_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .supply_low(supply_low),
        .dq(dq), .dq_oe(dq_oe), .op_fail(op_fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        report();
    end

    task automatic bus_write(input logic [8:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; din = v; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dq; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_done(input logic [8:0] a, output logic [7:0] r1,
                             output logic [7:0] r2, output logic [7:0] last);
        logic [7:0] prev, cur;
        bus_read(a, r1);
        bus_read(a, r2);
        prev = r2;
        cur  = r2;
        for (int k = 0; k < 3000; k++) begin
            bus_read(a, cur);
            if (cur == prev) break;
            prev = cur;
        end
        last = cur;
    endtask

    function automatic logic [2:0] sec_of(input logic [8:0] a);
        return a[8:6];
    endfunction

    task automatic do_program(input logic [8:0] a, input logic [7:0] v);
        logic [7:0] r1, r2, last, expv;
        expv = model[a] & v;
        bus_write(9'h000, 8'hA0);
        bus_write(a, v);
        wait_done(a, r1, r2, last);
        check(r1 == {~v[7], r1[6], 6'b0}, "R5 prog status", r1, {~v[7], r1[6], 6'b0});
        check(r1[6] != r2[6], "R6 toggle", r2, {r2[7], ~r1[6], r2[5:0]});
        check(last == expv, "R4 program result", last, expv);
        check(op_fail == (expv != v), "R7 fail flag", op_fail, expv != v);
        model[a] = expv;
    endtask

    task automatic do_erase(input logic [7:0] mask);
        logic [7:0] r1, r2, last;
        logic [8:0] probe;
        probe = '0;
        bus_write(9'h000, 8'h80);
        for (int s = 0; s < 8; s++)
            if (mask[s]) begin
                bus_write({3'(s), 6'h05}, 8'h30);
                if (probe == '0) probe = {3'(s), 6'h00};
            end
        for (int i = 0; i < DEPTH; i++) if (mask[sec_of(9'(i))]) model[i] = 8'hFF;
        wait_done(probe, r1, r2, last);
        check(r1[7] == 1'b0 && r1[5:0] == 6'b0, "R5 erase status", r1, {1'b0, r1[6], 6'b0});
        check(r1[6] != r2[6], "R6 toggle erase", r2, {r2[7], ~r1[6], r2[5:0]});
        check(last == 8'hFF, "R8 R10 erased", last, 8'hFF);
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dq_oe == 1'b0, "R1 oe", dq_oe, 0);
        check(op_fail == 1'b0, "R1 fail", op_fail, 0);
        bus_read(9'h000, v); check(v == 8'hFF, "R1 byte0", v, 8'hFF);
        bus_read(9'h1FF, v); check(v == 8'hFF, "R1 last", v, 8'hFF);

        // R3 drive only while both strobes low
        @(negedge clk); addr = 9'h010; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); check(dq_oe == 1'b1, "R3 driving", dq_oe, 1); ce_n = 1'b1;
        @(negedge clk); check(dq_oe == 1'b0 && dq == 8'h00, "R3 released", dq_oe, 0); oe_n = 1'b1;

        // R4 R5 R6 directed program (bit7 = 0)
        do_program(9'h012, 8'h5A);
        bus_read(9'h012, v); check(v == 8'h5A, "R6 stable after", v, 8'h5A);

        // R2 write with oe low is ignored
        @(negedge clk); addr = 9'h000; din = 8'hA0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        bus_write(9'h020, 8'h33);
        bus_read(9'h020, v); check(v == 8'hFF, "R2 ignored write", v, 8'hFF);

        // R7 impossible program, then clear
        do_program(9'h012, 8'hFF);
        check(op_fail == 1'b1, "R7 raised", op_fail, 1);
        bus_write(9'h000, 8'hF0);
        @(negedge clk); check(op_fail == 1'b0, "R7 cleared", op_fail, 0);

        // R11 supply low blocks writes
        supply_low = 1'b1;
        bus_write(9'h000, 8'hA0);
        bus_write(9'h030, 8'h00);
        supply_low = 1'b0;
        bus_read(9'h030, v); check(v == 8'hFF, "R11 blocked", v, 8'hFF);

        // R12 cancelled erase
        do_program(9'h085, 8'h11);
        do_program(9'h045, 8'h77);
        bus_write(9'h000, 8'h80);
        bus_write(9'h085, 8'h30);
        bus_write(9'h000, 8'h55);
        repeat (40) @(negedge clk);
        bus_read(9'h085, v); check(v == 8'h11, "R12 abort", v, 8'h11);

        // R8 R10 two-sector erase, sector 1 kept
        do_erase(8'b0000_0101);
        bus_read(9'h085, v); check(v == 8'hFF, "R8 sector2", v, 8'hFF);
        bus_read(9'h012, v); check(v == 8'hFF, "R8 sector0", v, 8'hFF);
        bus_read(9'h045, v); check(v == 8'h77, "R8 sector1 kept", v, 8'h77);

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [8:0] a;
            if (($urandom % 10) == 0) begin
                logic [7:0] m;
                m = 8'($urandom);
                if (m == 8'h00) m = 8'h10;
                do_erase(m);
            end else begin
                a = 9'($urandom);
                do_program(a, 8'($urandom));
            end
            a = 9'($urandom);
            bus_read(a, v); check(v == model[a], "R4 R8 random readback", v, model[a]);
        end

        // R9 chip erase
        bus_write(9'h000, 8'h80);
        bus_write(9'h000, 8'h10);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        begin
            logic [7:0] r1, r2, last;
            wait_done(9'h0C0, r1, r2, last);
            check(r1[7] == 1'b0, "R5 chip status", r1, 0);
            check(last == 8'hFF, "R9 chip erase", last, 8'hFF);
        end
        for (int i = 0; i < DEPTH; i += 7) begin
            bus_read(9'(i), v); check(v == 8'hFF, "R9 sweep", v, 8'hFF);
        end
        report();
    end
endmodule